// File: doc/BRIEF.md
# Segment Descriptor Load and Access Check Unit

This unit holds a small set of segment registers for a protected-mode address path. Each register stores a 16-bit selector together with a hidden copy of the descriptor that was fetched when the selector was loaded. The descriptors live in two internal tables, a global one and a local one. Software fills the tables through a write port.

A selector load reads the addressed descriptor and checks it. If every check passes, the descriptor is copied into the hidden cache. If a check fails, the load reports a fault code and leaves the register as it was. After a load, memory accesses use the translate port. That port takes a segment number, an offset and an access kind. It checks the access against the cached descriptor, then returns either the linear address or a fault code.

Segment register 0 is the code segment. The low two bits of its selector give the current privilege level. Load responses and translate responses both appear one clock cycle after their request.

Top module: `seg_desc_unit`

## Requirements
- R1: Selector fields are decoded as follows. Bits [1:0] are the requested privilege level (RPL). Bit 2 selects the local table when 1 and the global table when 0. Bits [15:3] are the table index. An index at or beyond the depth of the selected table fails the load with a general-protection fault (code 2'b01).
- R2: A table write stores a 64-bit descriptor at the given index of the table chosen by `tbl_wr_local`. The descriptor bits are: [31:0] base, [51:32] limit, [55:52] type, [56] normal (1 means code or data, 0 means system), [58:57] descriptor privilege level (DPL), [59] present, [60] granularity.
- R3: If the descriptor passes every other load check but its present bit is 0, the load fails with a not-present fault (code 2'b10). Every general-protection check takes priority over this one.
- R4: A load that faults leaves the hidden cache of every segment register unchanged.
- R5: A null selector (index 0 with bit 2 clear, any RPL) loads into a data register without a fault. Every later access through that register faults with code 2'b01. Loading a null selector into register 0 faults with code 2'b01.
- R6: A granted access returns linear address = cached base + offset, modulo 2^32, with fault code 2'b00.
- R7: When the granularity bit is 0, the limit counts bytes. An offset equal to the limit is granted. An offset above the limit faults with code 2'b01.
- R8: When the granularity bit is 1, the byte limit is the 20-bit limit shifted left by 12 with the low 12 bits set to 1.
- R9: For a data register, both the load and every access require max(current privilege level, the selector's RPL) <= DPL. A violation faults with code 2'b01.
- R10: Type bit 3 marks a code segment. Type bit 1 means writable for a data segment and readable for a code segment. Access kinds are 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 reserved. Each of these faults with code 2'b01:
  - a write to code or to read-only data;
  - a fetch from data;
  - a read from execute-only code;
  - the reserved kind;
  - a system descriptor load;
  - loading execute-only code into a data register;
  - loading non-code into register 0;
  - loading register 0 with RPL different from DPL.
- R11: The current privilege level is the RPL of register 0's selector. After reset, register 0 holds a ring-0 readable code segment with base 0 and a 4 GB limit. The data registers hold null, and no response is active.
- R12: A load or translate request produces its done pulse exactly one cycle later. The done pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Descriptor table write strobe |
| tbl_wr_local | input | 1 | Selects the table to write: 1 local, 0 global |
| tbl_wr_index | input | 13 | Table entry to write |
| tbl_wr_data | input | 64 | Descriptor to store |
| ld_valid | input | 1 | Selector load request |
| ld_seg | input | SEG_W | Segment register to load |
| ld_selector | input | 16 | Selector value |
| ld_done | output | 1 | Load response valid |
| ld_fault | output | 2 | Load fault code |
| xl_valid | input | 1 | Translate request |
| xl_seg | input | SEG_W | Segment register used by the access |
| xl_offset | input | 32 | Offset within the segment |
| xl_kind | input | 2 | Access kind |
| xl_done | output | 1 | Translate response valid |
| xl_fault | output | 2 | Translate fault code |
| xl_linear | output | 32 | Linear address of a granted access |
| cpl | output | 2 | Current privilege level |

## Verification
The bench uses the default parameters: four segment registers and eight entries in each table. With these values, entries 8 and 9 are out of range, so the index check can be exercised in both tables. Four registers are also enough to keep a code segment, a valid data segment, a null segment and a scratch register live at the same time. That lets the bench confirm that a faulted load left an older translation intact, and that a change of current privilege level alters the access result through a segment that was loaded earlier.

// File: rtl/seg_pkg.sv
package seg_pkg;

    // Fault codes returned by both ports
    localparam logic [1:0] FLT_NONE = 2'b00;
    localparam logic [1:0] FLT_GP   = 2'b01;
    localparam logic [1:0] FLT_NP   = 2'b10;

    // Access kinds
    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    // In-memory descriptor layout (LSB first: base, limit, type, normal, dpl, present, gran)
    typedef struct packed {
        logic [2:0]  rsvd;
        logic        gran;
        logic        present;
        logic [1:0]  dpl;
        logic        normal;
        logic [3:0]  typ;
        logic [19:0] limit;
        logic [31:0] base;
    } desc_t;

    // Hidden per-register state
    typedef struct packed {
        logic        valid;
        logic [15:0] sel;
        logic [31:0] base;
        logic [19:0] limit;
        logic [3:0]  typ;
        logic [1:0]  dpl;
        logic        gran;
    } seg_cache_t;

    localparam seg_cache_t FLAT_CODE = '{valid: 1'b1, sel: 16'h0000, base: 32'h0,
                                         limit: 20'hFFFFF, typ: 4'b1010, dpl: 2'd0,
                                         gran: 1'b1};

    function automatic logic [1:0] pmax(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data,
    output logic             rd_hit
);
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [63:0] mem_q [ENTRIES];
    logic [63:0] mem_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (wr_idx <= LAST)) begin
            mem_d[wr_idx[AW-1:0]] = wr_data;
        end
        rd_hit  = (rd_idx <= LAST);
        rd_data = rd_hit ? mem_q[rd_idx[AW-1:0]] : 64'h0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_q[i] <= rst_n ? mem_d[i] : 64'h0;
        end
    end

endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
    import seg_pkg::*;
(
    input  logic [15:0] selector,
    input  logic        to_code_reg,
    input  logic        seg_ok,
    input  logic [1:0]  cur_pl,
    input  desc_t       desc,
    input  logic        in_range,
    output logic [1:0]  fault,
    output seg_cache_t  entry
);
    logic       is_null;
    logic [1:0] rpl;

    always_comb begin
        rpl     = selector[1:0];
        is_null = (selector[15:3] == 13'd0) && !selector[2];
        fault   = FLT_NONE;

        entry.valid = !is_null;
        entry.sel   = selector;
        entry.base  = desc.base;
        entry.limit = desc.limit;
        entry.typ   = desc.typ;
        entry.dpl   = desc.dpl;
        entry.gran  = desc.gran;

        if (!seg_ok) begin
            fault = FLT_GP;
        end else if (is_null) begin
            fault = to_code_reg ? FLT_GP : FLT_NONE;
        end else if (!in_range || !desc.normal || (desc.rsvd != 3'd0)) begin
            fault = FLT_GP;
        end else if (to_code_reg) begin
            if (!desc.typ[3] || (desc.dpl != rpl)) fault = FLT_GP;
        end else begin
            if (desc.typ[3] && !desc.typ[1]) fault = FLT_GP;
            else if (pmax(cur_pl, rpl) > desc.dpl) fault = FLT_GP;
        end

        if (fault == FLT_NONE && !is_null && !desc.present) begin
            fault = FLT_NP;
        end
    end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_pkg::*;
(
    input  seg_cache_t  entry,
    input  logic        via_code_reg,
    input  logic [1:0]  cur_pl,
    input  logic [31:0] offset,
    input  logic [1:0]  kind,
    output logic [1:0]  fault,
    output logic [31:0] linear,
    output logic [31:0] byte_limit
);
    logic is_code;
    logic rw_bit;

    always_comb begin
        is_code    = entry.typ[3];
        rw_bit     = entry.typ[1];
        byte_limit = entry.gran ? {entry.limit, 12'hFFF} : {12'h000, entry.limit};
        linear     = entry.base + offset;
        fault      = FLT_NONE;

        if (!entry.valid) begin
            fault = FLT_GP;
        end else if (offset > byte_limit) begin
            fault = FLT_GP;
        end else begin
            unique case (kind)
                ACC_READ:  if (is_code && !rw_bit) fault = FLT_GP;
                ACC_WRITE: if (is_code || !rw_bit) fault = FLT_GP;
                ACC_FETCH: if (!is_code) fault = FLT_GP;
                default:   fault = FLT_GP;
            endcase
            if (!via_code_reg && (pmax(cur_pl, entry.sel[1:0]) > entry.dpl)) fault = FLT_GP;
        end
    end

endmodule

// File: rtl/seg_desc_unit.sv
module seg_desc_unit
    import seg_pkg::*;
#(
    parameter int NSEG        = 4,
    parameter int GDT_ENTRIES = 8,
    parameter int LDT_ENTRIES = 8,
    localparam int SEG_W      = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IDX_W      = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic             tbl_wr_local,
    input  logic [IDX_W-1:0] tbl_wr_index,
    input  logic [63:0]      tbl_wr_data,
    input  logic             ld_valid,
    input  logic [SEG_W-1:0] ld_seg,
    input  logic [15:0]      ld_selector,
    output logic             ld_done,
    output logic [1:0]       ld_fault,
    input  logic             xl_valid,
    input  logic [SEG_W-1:0] xl_seg,
    input  logic [31:0]      xl_offset,
    input  logic [1:0]       xl_kind,
    output logic             xl_done,
    output logic [1:0]       xl_fault,
    output logic [31:0]      xl_linear,
    output logic [1:0]       cpl
);
    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NSEG - 1);

    typedef struct packed {
        seg_cache_t [NSEG-1:0] cache;
        logic                  ld_done;
        logic [1:0]            ld_fault;
        logic                  xl_done;
        logic [1:0]            xl_fault;
        logic [31:0]           xl_linear;
    } state_t;

    state_t state_d, state_q;

    // Two descriptor tables: index 0 global, index 1 local
    logic [63:0] tbl_rd   [2];
    logic        tbl_hit  [2];

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        seg_desc_table #(
            .ENTRIES (t == 0 ? GDT_ENTRIES : LDT_ENTRIES),
            .IDX_W   (IDX_W)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tbl_wr_en && (tbl_wr_local == 1'(t))),
            .wr_idx  (tbl_wr_index),
            .wr_data (tbl_wr_data),
            .rd_idx  (ld_selector[15:3]),
            .rd_data (tbl_rd[t]),
            .rd_hit  (tbl_hit[t])
        );
    end

    desc_t      ld_desc;
    logic       ld_hit;
    logic       ld_seg_ok;
    logic [1:0] ld_fault_now;
    seg_cache_t ld_entry;
    logic [1:0] cur_pl;

    assign cur_pl    = state_q.cache[0].sel[1:0];
    assign ld_desc   = desc_t'(tbl_rd[ld_selector[2]]);
    assign ld_hit    = tbl_hit[ld_selector[2]];
    assign ld_seg_ok = (ld_seg <= SEG_LAST);

    seg_load_check u_ld (
        .selector    (ld_selector),
        .to_code_reg (ld_seg == '0),
        .seg_ok      (ld_seg_ok),
        .cur_pl      (cur_pl),
        .desc        (ld_desc),
        .in_range    (ld_hit),
        .fault       (ld_fault_now),
        .entry       (ld_entry)
    );

    seg_cache_t  xl_entry;
    logic [1:0]  xl_fault_now;
    logic [31:0] xl_lin_now;
    logic [31:0] xl_lim_now;

    assign xl_entry = (xl_seg <= SEG_LAST) ? state_q.cache[xl_seg] : '0;

    seg_access_check u_xl (
        .entry        (xl_entry),
        .via_code_reg (xl_seg == '0),
        .cur_pl       (cur_pl),
        .offset       (xl_offset),
        .kind         (xl_kind),
        .fault        (xl_fault_now),
        .linear       (xl_lin_now),
        .byte_limit   (xl_lim_now)
    );

    always_comb begin
        state_d          = state_q;
        state_d.ld_done  = ld_valid;
        state_d.ld_fault = ld_valid ? ld_fault_now : FLT_NONE;
        if (ld_valid && (ld_fault_now == FLT_NONE)) begin
            state_d.cache[ld_seg] = ld_entry;
        end
        state_d.xl_done   = xl_valid;
        state_d.xl_fault  = xl_valid ? xl_fault_now : FLT_NONE;
        state_d.xl_linear = (xl_valid && xl_fault_now == FLT_NONE) ? xl_lin_now : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.cache[0] <= FLAT_CODE;
        end else begin
            state_q <= state_d;
        end
    end

    assign ld_done   = state_q.ld_done;
    assign ld_fault  = state_q.ld_fault;
    assign xl_done   = state_q.xl_done;
    assign xl_fault  = state_q.xl_fault;
    assign xl_linear = state_q.xl_linear;
    assign cpl       = cur_pl;

    // R12
    ld_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_done);

    // R12
    xl_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> xl_done);

    // R4
    fault_keeps_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_fault_now != FLT_NONE) |=> $stable(state_q.cache));

    // R7
    grant_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_fault_now == FLT_NONE) |->
            (xl_offset <= (xl_entry.gran ? {xl_entry.limit, 12'hFFF} : {12'h0, xl_entry.limit})));

    // R9
    data_load_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_seg != '0 && ld_fault_now == FLT_NONE && ld_entry.valid) |->
            (pmax(cur_pl, ld_selector[1:0]) <= ld_desc.dpl));

    // R3
    np_only_when_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_fault_now == FLT_NP) |-> !ld_desc.present);

endmodule

// File: tb/tb_seg_desc_unit.sv
module tb_seg_desc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0, tbl_wr_local = 1'b0;
    logic [12:0] tbl_wr_index = '0;
    logic [63:0] tbl_wr_data = '0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_seg = '0;
    logic [15:0] ld_selector = '0;
    logic        ld_done;
    logic [1:0]  ld_fault;
    logic        xl_valid = 1'b0;
    logic [1:0]  xl_seg = '0;
    logic [31:0] xl_offset = '0;
    logic [1:0]  xl_kind = '0;
    logic        xl_done;
    logic [1:0]  xl_fault;
    logic [31:0] xl_linear;
    logic [1:0]  cpl;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    seg_desc_unit dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_local(tbl_wr_local),
        .tbl_wr_index(tbl_wr_index), .tbl_wr_data(tbl_wr_data),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_selector(ld_selector),
        .ld_done(ld_done), .ld_fault(ld_fault),
        .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_offset(xl_offset), .xl_kind(xl_kind),
        .xl_done(xl_done), .xl_fault(xl_fault), .xl_linear(xl_linear), .cpl(cpl)
    );

    function automatic logic [63:0] mkdesc(input logic [31:0] base, input logic [19:0] lim,
                                           input logic [3:0] typ, input logic normal,
                                           input logic [1:0] dpl, input logic pres,
                                           input logic gran);
        return {3'b000, gran, pres, dpl, normal, typ, lim, base};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic loc, input logic [12:0] idx, input logic [63:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_local = loc; tbl_wr_index = idx; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic load(input string req, input logic [1:0] seg, input logic [15:0] sel,
                        input logic [1:0] exp_f);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = seg; ld_selector = sel;
        @(negedge clk);
        ld_valid = 1'b0;
        check(req, {ld_done, ld_fault}, {1'b1, exp_f});
        @(negedge clk);
        check({req, " pulse"}, ld_done, 1'b0);
    endtask

    task automatic xlate(input string req, input logic [1:0] seg, input logic [31:0] off,
                         input logic [1:0] kind, input logic [1:0] exp_f,
                         input logic [31:0] exp_lin);
        @(negedge clk);
        xl_valid = 1'b1; xl_seg = seg; xl_offset = off; xl_kind = kind;
        @(negedge clk);
        xl_valid = 1'b0;
        check(req, {xl_done, xl_fault}, {1'b1, exp_f});
        if (exp_f == 2'b00) check({req, " addr"}, xl_linear, exp_lin);
    endtask

    task automatic t_reset;
        check("R11 cpl", cpl, 2'd0);
        check("R11 idle", {ld_done, xl_done}, 2'b00);
        xlate("R11 flat code read", 2'd0, 32'h0000_1234, 2'b00, 2'b00, 32'h0000_1234);
        xlate("R11 null data reg", 2'd1, 32'h0, 2'b00, 2'b01, 32'h0);
    endtask

    task automatic t_fill;
        wr_tbl(1'b0, 13'd1, mkdesc(32'h1000_0000, 20'h00FFF, 4'b0010, 1, 2'd3, 1, 0));
        wr_tbl(1'b0, 13'd2, mkdesc(32'h0000_2000, 20'h00010, 4'b0000, 1, 2'd0, 1, 0));
        wr_tbl(1'b0, 13'd3, mkdesc(32'h4000_0000, 20'hFFFFF, 4'b1000, 1, 2'd0, 1, 1));
        wr_tbl(1'b0, 13'd4, mkdesc(32'h0000_9000, 20'h000FF, 4'b0010, 1, 2'd3, 0, 0));
        wr_tbl(1'b0, 13'd5, mkdesc(32'h0000_A000, 20'h000FF, 4'b0010, 0, 2'd3, 1, 0));
        wr_tbl(1'b0, 13'd6, mkdesc(32'h8000_0000, 20'h00002, 4'b0010, 1, 2'd3, 1, 1));
        wr_tbl(1'b0, 13'd7, mkdesc(32'h0000_0000, 20'hFFFFF, 4'b1010, 1, 2'd3, 1, 1));
        wr_tbl(1'b1, 13'd1, mkdesc(32'h0000_5000, 20'h000FF, 4'b0010, 1, 2'd3, 1, 0));
    endtask

    task automatic t_basic;
        load("R2 load global 1", 2'd1, 16'h0008, 2'b00);
        xlate("R6 base plus offset", 2'd1, 32'h10, 2'b00, 2'b00, 32'h1000_0010);
        load("R1 local table select", 2'd2, 16'h000C, 2'b00);
        xlate("R7 offset equals limit", 2'd2, 32'hFF, 2'b00, 2'b00, 32'h0000_50FF);
        xlate("R7 offset past limit", 2'd2, 32'h100, 2'b00, 2'b01, 32'h0);
    endtask

    task automatic t_pages;
        load("R8 load paged", 2'd3, 16'h0030, 2'b00);
        xlate("R8 last byte of page", 2'd3, 32'h2FFF, 2'b00, 2'b00, 32'h8000_2FFF);
        xlate("R8 beyond pages", 2'd3, 32'h3000, 2'b00, 2'b01, 32'h0);
    endtask

    task automatic t_absent;
        load("R3 not present", 2'd1, 16'h0020, 2'b10);
        xlate("R4 cache kept", 2'd1, 32'h10, 2'b00, 2'b00, 32'h1000_0010);
        load("R1 global index out of range", 2'd1, 16'h0048, 2'b01);
        load("R1 local index out of range", 2'd1, 16'h0044, 2'b01);
        xlate("R4 cache kept after GP", 2'd1, 32'h20, 2'b00, 2'b00, 32'h1000_0020);
    endtask

    task automatic t_types;
        load("R10 system descriptor", 2'd3, 16'h0028, 2'b01);
        xlate("R10 write writable data", 2'd2, 32'h4, 2'b01, 2'b00, 32'h0000_5004);
        load("R10 load read-only data", 2'd1, 16'h0010, 2'b00);
        xlate("R10 write read-only", 2'd1, 32'h4, 2'b01, 2'b01, 32'h0);
        xlate("R10 fetch from data", 2'd1, 32'h4, 2'b10, 2'b01, 32'h0);
        xlate("R10 read read-only", 2'd1, 32'h4, 2'b00, 2'b00, 32'h0000_2004);
        xlate("R10 reserved kind", 2'd1, 32'h4, 2'b11, 2'b01, 32'h0);
        load("R10 exec-only into data reg", 2'd3, 16'h0018, 2'b01);
        load("R10 data into code reg", 2'd0, 16'h0008, 2'b01);
        load("R10 code reg rpl ne dpl", 2'd0, 16'h001B, 2'b01);
        xlate("R10 read flat code", 2'd0, 32'h40, 2'b00, 2'b00, 32'h40);
        xlate("R10 write to code", 2'd0, 32'h40, 2'b01, 2'b01, 32'h0);
    endtask

    task automatic t_priv;
        load("R11 ring 3 code", 2'd0, 16'h003B, 2'b00);
        check("R11 cpl follows code rpl", cpl, 2'd3);
        xlate("R9 access dpl0 data from ring 3", 2'd1, 32'h4, 2'b00, 2'b01, 32'h0);
        load("R9 load dpl3 with rpl3", 2'd2, 16'h000B, 2'b00);
        xlate("R9 access dpl3 data", 2'd2, 32'h8, 2'b01, 2'b00, 32'h1000_0008);
        load("R9 load dpl0 from ring 3", 2'd3, 16'h0010, 2'b01);
        xlate("R9 fetch via code reg", 2'd0, 32'h100, 2'b10, 2'b00, 32'h100);
    endtask

    task automatic t_null;
        load("R5 null into data reg", 2'd2, 16'h0003, 2'b00);
        xlate("R5 access through null", 2'd2, 32'h0, 2'b00, 2'b01, 32'h0);
        load("R5 null into code reg", 2'd0, 16'h0000, 2'b01);
        check("R5 cpl unchanged", cpl, 2'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fill;
        t_basic;
        t_pages;
        t_absent;
        t_types;
        t_priv;
        t_null;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule